// File: doc/BRIEF.md
# Transport Stream Packet Aligner

This block finds packet boundaries in a byte-wide transport stream. Bytes arrive with a valid strobe, and the block knows nothing about where packets start. It hunts for a programmable sync byte. It then checks that the same value comes back after exactly one packet length, and only trusts the alignment once a programmable number of those repeats have been seen in a row. After that it forwards every byte, marking the first byte of each packet. A single missing sync byte drops the alignment again.

All settings come from one 32-bit control word, which is expected to stay constant while the stream runs. The sync byte value sits in bits 23:16, the packet length in bits 15:4 and the required run of consecutive repeats in bits 3:0. Usual settings are 0x47, 188 and 7. The packet length must be at least 2. Downstream logic sees registered outputs: each forwarded byte leaves one clock after it entered.

Top module: `ts_pkt_aligner`

## Requirements
- R1: While rst_n is low at a clock edge, and after reset is released, out_valid, out_sop, out_lock and lock_lost are all 0.
- R2: The control word is decoded as follows. Bits 23:16 give the sync value, bits 15:4 the packet length in bytes, and bits 3:0 the number of consecutive repeat hits needed for lock. A run field of 0 or 5 behaves exactly like 7.
- R3: While searching, bytes that differ from the sync value are ignored and produce no output. The first byte that equals the sync value starts a candidate packet at offset 0.
- R4: While verifying, the byte at offset equal to the packet length must equal the sync value, and that byte becomes the new offset 0. If it does not match, the block returns to searching, clears its run count and forwards nothing, so a full new run is then needed.
- R5: Lock is declared on the repeat hit that brings the run to the configured count. That sync byte is the first byte forwarded, with out_sop=1 and out_lock=1.
- R6: While locked, every valid input byte appears on out_byte with out_valid=1 exactly one clock later. Cycles with in_valid low produce out_valid=0 and do not advance the packet offset.
- R7: While locked, a byte at an expected sync position that is not the sync value has three effects. It clears out_lock, it raises lock_lost for exactly one cycle (aligned with the output slot of that byte), and it is not forwarded. The block then searches again.
- R8: A byte equal to the sync value at any offset other than 0 is forwarded as ordinary data with out_sop=0. It does not disturb the alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Packed control word (sync 23:16, length 15:4, run 3:0) |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input stream byte |
| out_valid | output | 1 | Forwarded byte strobe (only while locked) |
| out_byte | output | 8 | Forwarded byte |
| out_sop | output | 1 | Forwarded byte is a packet's first byte |
| out_lock | output | 1 | Block is in lock |
| lock_lost | output | 1 | One-cycle pulse when lock is dropped |

## Verification
The hardest situation to reach from the ports is a miss in the verify phase after part of a run has been built. To expose it, a bench has to follow that miss with exactly one run fewer than required and confirm that nothing is forwarded yet. Only then does it confirm that the next repeat locks. The stimulus does this with short packets, a run count of three and a corrupted sync byte after one hit. A sync value placed mid-packet, together with an idle gap while locked, checks that neither one shifts the boundary.

// File: rtl/ts_align_pkg.sv
// Package: shared types and field layout for the transport stream packet aligner.
// Assumes the control word format: sync 23:16, length 15:4, run 3:0.
package ts_align_pkg;
    localparam int SYNC_W = 8;
    localparam int LEN_W  = 12;
    localparam int RUN_W  = 4;
    localparam int SYNC_LSB = 16;
    localparam int LEN_LSB  = 4;
    localparam int RUN_LSB  = 0;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_t;

    typedef struct packed {
        logic [SYNC_W-1:0] sync_val;
        logic [LEN_W-1:0]  pkt_len;
        logic [RUN_W-1:0]  run_need;
    } align_cfg_t;
endpackage

// File: rtl/ts_cfg_decode.sv
// Module: unpacks the control word into sync value, packet length and run count.
// Run values listed as unsupported (0 and 5) are replaced by the fallback count.
// Assumes the control word is static while the stream runs.
module ts_cfg_decode
    import ts_align_pkg::*;
#(
    parameter int FALLBACK_RUN = 7
) (
    input  logic [31:0] cfg_word,
    output align_cfg_t  cfg
);
    localparam logic [RUN_W-1:0] FALLBACK = RUN_W'(FALLBACK_RUN);

    logic [RUN_W-1:0] raw_run;
    logic             unused_cfg_hi;

    assign unused_cfg_hi = ^cfg_word[31:SYNC_LSB+SYNC_W];
    assign raw_run       = cfg_word[RUN_LSB +: RUN_W];

    // Field extraction with substitution of unsupported run counts.
    always_comb begin
        cfg.sync_val = cfg_word[SYNC_LSB +: SYNC_W];
        cfg.pkt_len  = cfg_word[LEN_LSB +: LEN_W];
        if (raw_run == '0 || raw_run == RUN_W'(5)) cfg.run_need = FALLBACK;
        else                                       cfg.run_need = raw_run;
    end
endmodule

// File: rtl/ts_pos_counter.sv
// Module: tracks the offset of the incoming byte within the current packet.
// A restart marks the current byte as offset 0; the counter wraps to 1 after
// the byte at offset pkt_len (which is the next packet's offset 0).
// Assumes pkt_len >= 2 and that only valid bytes advance the offset.
module ts_pos_counter
    import ts_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             restart,
    input  logic             active,
    input  logic [LEN_W-1:0] pkt_len,
    output logic             at_boundary
);
    logic [LEN_W-1:0] pos_q;

    assign at_boundary = active && (pos_q == pkt_len);

    // Offset register: set on restart, advance or wrap on each valid byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pos_q <= '0;
        else if (restart)            pos_q <= LEN_W'(1);
        else if (active && in_valid) pos_q <= at_boundary ? LEN_W'(1) : pos_q + LEN_W'(1);
    end

    // R4: while tracking a packet, the offset never leaves 1..pkt_len.
    a_r4_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pos_q >= LEN_W'(1) && pos_q <= pkt_len));
endmodule

// File: rtl/ts_lock_fsm.sv
// Module: search / verify / locked state machine with the consecutive-hit run counter.
// Produces next-state based decisions for the output stage: forward, sop, lost.
// Assumes run_need >= 1 (guaranteed by the configuration decoder).
module ts_lock_fsm
    import ts_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             is_sync,
    input  logic             at_boundary,
    input  logic [RUN_W-1:0] run_need,
    output logic             counting,
    output logic             restart,
    output logic             fwd_next,
    output logic             sop_next,
    output logic             lost_next
);
    align_state_t     state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             hit, miss;
    logic [RUN_W:0]   run_inc;

    assign hit      = in_valid && at_boundary && is_sync;
    assign miss     = in_valid && at_boundary && !is_sync;
    assign run_inc  = {1'b0, run_q} + 1'b1;
    assign counting = (state_q != ST_SEARCH);

    // Next-state and run-count decisions for the current byte.
    always_comb begin
        state_d   = state_q;
        run_d     = run_q;
        restart   = 1'b0;
        lost_next = 1'b0;
        unique case (state_q)
            ST_SEARCH: begin
                if (in_valid && is_sync) begin
                    state_d = ST_VERIFY;
                    run_d   = '0;
                    restart = 1'b1;
                end
            end
            ST_VERIFY: begin
                if (hit) begin
                    if (run_inc == {1'b0, run_need}) begin
                        state_d = ST_LOCKED;
                        run_d   = '0;
                    end else begin
                        run_d = run_inc[RUN_W-1:0];
                    end
                end else if (miss) begin
                    state_d = ST_SEARCH;
                    run_d   = '0;
                end
            end
            ST_LOCKED: begin
                if (miss) begin
                    state_d   = ST_SEARCH;
                    lost_next = 1'b1;
                end
            end
            default: begin
                state_d = ST_SEARCH;
                run_d   = '0;
            end
        endcase
    end

    assign fwd_next = in_valid && (state_d == ST_LOCKED);
    assign sop_next = hit && (state_d == ST_LOCKED);

    // State and run-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // R5: the run count stays below the required count (lock is taken on reaching it).
    a_r5_run_below_need: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < run_need);
    // R3: leaving search always goes through verify, never straight to locked.
    a_r3_search_to_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |=> (state_q != ST_LOCKED));
endmodule

// File: rtl/ts_pkt_aligner.sv
// Module: top of the transport stream packet aligner.
// Decodes the control word, tracks packet offsets, runs the lock state machine
// and registers the forwarded stream with start-of-packet, lock and lock-lost flags.
// Assumes a static control word and a packet length of at least 2.
module ts_pkt_aligner
    import ts_align_pkg::*;
#(
    parameter int FALLBACK_RUN = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_word,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        out_valid,
    output logic [7:0]  out_byte,
    output logic        out_sop,
    output logic        out_lock,
    output logic        lock_lost
);
    align_cfg_t cfg;
    logic       is_sync, at_boundary, counting, restart;
    logic       fwd_next, sop_next, lost_next;

    ts_cfg_decode #(.FALLBACK_RUN(FALLBACK_RUN)) u_decode (
        .cfg_word (cfg_word),
        .cfg      (cfg)
    );

    assign is_sync = (in_byte == cfg.sync_val);

    ts_pos_counter u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .restart     (restart),
        .active      (counting),
        .pkt_len     (cfg.pkt_len),
        .at_boundary (at_boundary)
    );

    ts_lock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .is_sync     (is_sync),
        .at_boundary (at_boundary),
        .run_need    (cfg.run_need),
        .counting    (counting),
        .restart     (restart),
        .fwd_next    (fwd_next),
        .sop_next    (sop_next),
        .lost_next   (lost_next)
    );

    // Output stage: one register between the input byte and the stream outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_sop   <= 1'b0;
            out_lock  <= 1'b0;
            lock_lost <= 1'b0;
        end else begin
            out_valid <= fwd_next;
            out_byte  <= fwd_next ? in_byte : out_byte;
            out_sop   <= sop_next;
            out_lock  <= (u_fsm.state_d == ST_LOCKED);
            lock_lost <= lost_next;
        end
    end

    // R8: a start-of-packet mark only accompanies a forwarded byte.
    a_r8_sop_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);
    // R6: bytes are only forwarded while in lock.
    a_r6_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_lock);
    // R5: lock is first shown together with a start-of-packet byte.
    a_r5_lock_rise_sop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_lock) |-> out_sop);
    // R7: lock-lost only follows a locked cycle and comes with lock cleared.
    a_r7_lost_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |-> (!out_lock && $past(out_lock)));
    // R7: lock-lost is a single-cycle pulse.
    a_r7_lost_single: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost |=> !lock_lost);
endmodule

// File: tb/ts_pkt_aligner_bench.sv
// Bench: scoreboard style. The driver queues the expected output for every
// cycle it drives; the monitor compares one queued item per clock.
module ts_pkt_aligner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = 32'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid, out_sop, out_lock, lock_lost;
    logic [7:0]  out_byte;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic       v;
        logic       s;
        logic       l;
        logic       ll;
        logic [7:0] b;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    ts_pkt_aligner u_ts_pkt_aligner (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
        .out_lock(out_lock), .lock_lost(lock_lost)
    );

    function automatic logic [31:0] mk_cfg(input logic [7:0] s, input int len, input int run);
        return {8'h00, s, 12'(len), 4'(run)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " valid"}, {31'b0, out_valid}, {31'b0, e.v});
            check({e.tag, " sop"},   {31'b0, out_sop},   {31'b0, e.s});
            check({e.tag, " lock"},  {31'b0, out_lock},  {31'b0, e.l});
            check({e.tag, " lost"},  {31'b0, lock_lost}, {31'b0, e.ll});
            if (e.v) check({e.tag, " byte"}, {24'b0, out_byte}, {24'b0, e.b});
        end
    end

    // Driver: one byte per cycle, expectation queued before the sampling edge.
    task automatic drive(input logic vld, input logic [7:0] b, input logic ev,
                         input logic es, input logic el, input logic ell, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = vld;
        in_byte  = b;
        e.v = ev; e.s = es; e.l = el; e.ll = ell; e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // One packet: first byte plus nfill filler bytes (never equal to the sync values used).
    task automatic pkt(input logic [7:0] first, input int nfill, input logic f_fwd,
                       input logic f_lost, input logic rest_lock, input string tag);
        drive(1'b1, first, f_fwd, f_fwd, f_fwd, f_lost, tag);
        for (int i = 0; i < nfill; i++)
            drive(1'b1, 8'(8'h20 + i), rest_lock, 1'b0, rest_lock, 1'b0, tag);
    endtask

    task automatic do_reset(input logic [31:0] cw);
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        cfg_word = cw;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // ---- R1: reset state ----
        do_reset(mk_cfg(8'h47, 8, 3));
        @(negedge clk);
        check("R1 reset outputs", {28'b0, out_valid, out_sop, out_lock, lock_lost}, 32'h0);

        // ---- R3: junk without sync is ignored ----
        for (int i = 0; i < 5; i++) drive(1'b1, 8'(8'h10 + i), 0, 0, 0, 0, "R3 junk ignored");
        // ---- R5: candidate + 3 hits -> lock on third hit ----
        pkt(8'h47, 7, 0, 0, 0, "R3 candidate");
        pkt(8'h47, 7, 0, 0, 0, "R5 hit1");
        pkt(8'h47, 7, 0, 0, 0, "R5 hit2");
        pkt(8'h47, 7, 1, 0, 1, "R5 lock on hit3");
        // ---- R6/R8: locked packet with idle gap and mid-packet sync value ----
        drive(1'b1, 8'h47, 1, 1, 1, 0, "R6 sop at boundary");
        drive(1'b1, 8'h21, 1, 0, 1, 0, "R6 data");
        drive(1'b0, 8'h99, 0, 0, 1, 0, "R6 idle gap");
        drive(1'b1, 8'h47, 1, 0, 1, 0, "R8 mid sync no sop");
        for (int i = 0; i < 5; i++) drive(1'b1, 8'(8'h23 + i), 1, 0, 1, 0, "R6 data");
        // ---- R7: missing sync while locked ----
        pkt(8'h00, 7, 0, 1, 0, "R7 loss");
        drive(1'b0, 8'h00, 0, 0, 0, 0, "R7 single pulse");

        // ---- R4: verify miss clears run, full run needed again ----
        do_reset(mk_cfg(8'h47, 8, 3));
        pkt(8'h47, 7, 0, 0, 0, "R4 candidate");
        pkt(8'h47, 7, 0, 0, 0, "R4 hit1");
        pkt(8'h5A, 7, 0, 0, 0, "R4 verify miss");
        pkt(8'h47, 7, 0, 0, 0, "R4 new candidate");
        pkt(8'h47, 7, 0, 0, 0, "R4 hit1 again");
        pkt(8'h47, 7, 0, 0, 0, "R4 hit2 no lock");
        pkt(8'h47, 3, 1, 0, 1, "R4 lock after full run");

        // ---- R2: field positions (sync B8, length 12, run 1) ----
        do_reset(mk_cfg(8'hB8, 12, 1));
        drive(1'b1, 8'h47, 0, 0, 0, 0, "R2 old sync ignored");
        pkt(8'hB8, 11, 0, 0, 0, "R2 candidate");
        pkt(8'hB8, 11, 1, 0, 1, "R2 lock run1 len12");
        drive(1'b1, 8'hB8, 1, 1, 1, 0, "R2 sop len12");

        // ---- R2: run field 0 behaves as 7 ----
        do_reset(mk_cfg(8'h47, 4, 0));
        pkt(8'h47, 3, 0, 0, 0, "R2 run0 candidate");
        for (int k = 0; k < 6; k++) pkt(8'h47, 3, 0, 0, 0, "R2 run0 no early lock");
        pkt(8'h47, 3, 1, 0, 1, "R2 run0 lock at 7");

        // ---- R2: run field 5 behaves as 7 ----
        do_reset(mk_cfg(8'h47, 4, 5));
        pkt(8'h47, 3, 0, 0, 0, "R2 run5 candidate");
        for (int k = 0; k < 6; k++) pkt(8'h47, 3, 0, 0, 0, "R2 run5 no early lock");
        pkt(8'h47, 3, 1, 0, 1, "R2 run5 lock at 7");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule